// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to 96 level-sensitive interrupt sources and presents two request lines to a processor. One line is for normal interrupts and one is for fast interrupts. The sources sit in banks of 32. Each bank can mask individual sources and can raise sources in software. Each source has its own line register. That register sets the source's priority and whether it is routed to the normal or the fast request.

For each class the controller picks the most urgent eligible source: it must be pending, unmasked, routed to that class, and pass the priority threshold. The controller latches that source's number and priority and raises the request line. The choice stays frozen until software writes an acknowledge bit to the control register. Arbitration then runs again on the next clock.

Software reaches every register through a simple 32-bit bus. A write takes effect at the clock edge on which the write strobe is high. Reads are combinational from the address. A soft reset is available through the configuration register.

Top module: `prio_intc`

## Requirements
- R1: After reset every source is masked (mask reads 0xFFFFFFFF in each bank), both request outputs are low, the threshold reads 0xFF, and status bit 0 reads 1.
- R2: Within bank b (base 0x80 + 0x20·b), mask reads at +0x04. Writing +0x0C sets the mask bits written as 1, and writing +0x08 clears the mask bits written as 1. Zero bits leave the mask unchanged. The set and clear aliases read 0.
- R3: Bank offset +0x00 reads the raw input levels of the bank's 32 sources, regardless of mask.
- R4: Writing 1s to bank offset +0x10 raises those sources in software, and writing 1s to +0x14 drops them. A raised source acts as if its input were high.
- R5: Bank offset +0x18 reads the sources that are pending (input or software), unmasked and routed to the normal request. Offset +0x1C reads the same for fast-routed sources. The threshold does not affect these views.
- R6: The line register of source n is at 0x100 + 4·n. Bits [7:2] hold the priority and bit 0 selects the fast route. A value of 0 means normal route at priority 0.
- R7: Among the eligible sources of a class, the lowest priority value wins, and a tie goes to the lower source number. The latched normal winner reads at 0x40 in bits [6:0], and its priority reads at 0x60.
- R8: The normal request output is high exactly while a winner is latched. The winner stays unchanged until bit 0 is written as 1 to the control register at 0x48. The output is then low for at least one cycle, and the next winner is latched on the following edge.
- R9: Fast-routed sources follow the same rules through their own latch: winner at 0x44, its priority at 0x64, and release by control bit 1.
- R10: The threshold register is at 0x68. The value 0xFF lets every priority through. Any other value lets only sources whose priority is below it be latched.
- R11: Writing 1 to bit 1 of the configuration register at 0x10 starts a soft reset. Status bit 0 (at 0x14) reads 0 in the following cycle, and every register returns to its R1 state at the next edge, after which status reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| src_in | input | 96 | Interrupt source levels |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench aims at the following corner cases:

- **Equal priorities.** Two sources share a priority. A reversed tie-break would report the higher source number.
- **Priority change while latched.** A source's priority is raised above the latched winner before the acknowledge. A controller that re-arbitrates continuously would swap the reported number before software released it.
- **Acknowledge and request in the same cycle.** The release must drop the request for one cycle and then latch the new winner. A design that skipped the drop would hide the acknowledge.
- **Threshold filtering.** A source above the threshold must stay visible in the pending view while never reaching the request line.
- **Soft reset.** It must show a busy status for exactly one cycle and restore masks, lines and threshold.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam logic [11:0] A_CFG   = 12'h010;
  localparam logic [11:0] A_STAT  = 12'h014;
  localparam logic [11:0] A_AIRQ  = 12'h040;
  localparam logic [11:0] A_AFIQ  = 12'h044;
  localparam logic [11:0] A_CTRL  = 12'h048;
  localparam logic [11:0] A_PIRQ  = 12'h060;
  localparam logic [11:0] A_PFIQ  = 12'h064;
  localparam logic [11:0] A_THR   = 12'h068;
  localparam logic [11:0] A_BANK0 = 12'h080;
  localparam logic [11:0] A_LINE0 = 12'h100;

  typedef enum logic [2:0] {
    B_RAW  = 3'd0,
    B_MASK = 3'd1,
    B_MCLR = 3'd2,
    B_MSET = 3'd3,
    B_SSET = 3'd4,
    B_SCLR = 3'd5,
    B_PIRQ = 3'd6,
    B_PFIQ = 3'd7
  } bank_reg_e;
endpackage

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr,
  input  bank_reg_e    sel,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] src,
  input  logic [W-1:0] fiq_sel,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] pend_irq_o,
  output logic [W-1:0] pend_fiq_o
);
  logic [W-1:0] mask_q, mask_d, swi_q, swi_d, live;
  logic         en;

  always_comb begin
    mask_d = mask_q;
    swi_d  = swi_q;
    if (clr) begin
      mask_d = '1;
      swi_d  = '0;
    end else if (wr) begin
      case (sel)
        B_MCLR:  mask_d = mask_q & ~wdata;
        B_MSET:  mask_d = mask_q | wdata;
        B_SSET:  swi_d  = swi_q | wdata;
        B_SCLR:  swi_d  = swi_q & ~wdata;
        default: ;
      endcase
    end
  end

  assign en = clr | wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      swi_q  <= '0;
    end else if (en) begin
      mask_q <= mask_d;
      swi_q  <= swi_d;
    end
  end

  assign live       = (src | swi_q) & ~mask_q;
  assign pend_irq_o = live & ~fiq_sel;
  assign pend_fiq_o = live & fiq_sel;
  assign mask_o     = mask_q;

  AST_MSET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr && sel == B_MSET) |=> ((mask_q & $past(wdata)) == $past(wdata))); // R2
  AST_MCLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr && sel == B_MCLR) |=> ((mask_q & $past(wdata)) == '0)); // R2
  AST_MASK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(wr && (sel == B_MSET || sel == B_MCLR))) |=> $stable(mask_q)); // R2
  AST_SWI_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr && sel == B_SSET) |=> ((swi_q & $past(wdata)) == $past(wdata))); // R4
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int N  = 96,
  parameter int PW = 6,
  parameter int SW = 7
) (
  input  logic [N-1:0]    cand,
  input  logic [N*PW-1:0] prio_flat,
  output logic            found,
  output logic [SW-1:0]   win,
  output logic [PW-1:0]   win_prio
);
  always_comb begin
    found    = 1'b0;
    win      = '0;
    win_prio = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || prio_flat[i*PW +: PW] < win_prio)) begin
        found    = 1'b1;
        win      = SW'(i);
        win_prio = prio_flat[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int N_SRC  = 96,
  parameter int PRIO_W = 6,
  parameter int THR_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [11:0]      bus_addr,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [N_SRC-1:0] src_in,
  output logic             irq_o,
  output logic             fiq_o
);
  localparam int NB = N_SRC / 32;
  localparam int SW = $clog2(N_SRC);

  logic clr, sr_pend_q, sr_pend_d;
  logic [THR_W-1:0] thr_q, thr_d;
  logic [PRIO_W-1:0] prio_q [N_SRC];
  logic [N_SRC-1:0] fsel_q, line_we, thr_ok, irq_cand, fiq_cand;
  logic [N_SRC-1:0] mask_all, pirq_all, pfiq_all;
  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic [NB-1:0] bank_wr;
  logic bank_hit, line_hit;
  int   bank_idx, line_idx;
  logic ack_irq, ack_fiq, cfg_wr, thr_wr;

  logic irq_found, fiq_found;
  logic [SW-1:0] irq_win, fiq_win, irq_num_q, fiq_num_q;
  logic [PRIO_W-1:0] irq_wpri, fiq_wpri, irq_pri_q, fiq_pri_q;
  logic irq_vld_q, fiq_vld_q, irq_vld_d, fiq_vld_d, irq_take, fiq_take;

  // ---------------- address decode ----------------
  always_comb begin
    bank_hit = (bus_addr >= A_BANK0) && (bus_addr < A_BANK0 + 12'(32 * NB));
    line_hit = (bus_addr >= A_LINE0) && (bus_addr < A_LINE0 + 12'(4 * N_SRC));
    bank_idx = int'((bus_addr - A_BANK0) >> 5);
    line_idx = int'((bus_addr - A_LINE0) >> 2);
    ack_irq  = bus_wr && bus_addr == A_CTRL && bus_wdata[0];
    ack_fiq  = bus_wr && bus_addr == A_CTRL && bus_wdata[1];
    cfg_wr   = bus_wr && bus_addr == A_CFG && bus_wdata[1];
    thr_wr   = bus_wr && bus_addr == A_THR;
    for (int b = 0; b < NB; b++) bank_wr[b] = bus_wr && bank_hit && bank_idx == b;
    for (int n = 0; n < N_SRC; n++) line_we[n] = bus_wr && line_hit && line_idx == n;
  end

  assign clr = sr_pend_q;

  // ---------------- banks ----------------
  for (genvar b = 0; b < NB; b++) begin : g_bank
    intc_bank #(.W(32)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .wr         (bank_wr[b]),
      .sel        (bank_reg_e'(bus_addr[4:2])),
      .wdata      (bus_wdata),
      .src        (src_in[b*32 +: 32]),
      .fiq_sel    (fsel_q[b*32 +: 32]),
      .mask_o     (mask_all[b*32 +: 32]),
      .pend_irq_o (pirq_all[b*32 +: 32]),
      .pend_fiq_o (pfiq_all[b*32 +: 32])
    );
  end

  // ---------------- line registers, threshold ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_q <= '0;
      for (int n = 0; n < N_SRC; n++) prio_q[n] <= '0;
    end else begin
      for (int n = 0; n < N_SRC; n++) begin
        if (clr) begin
          prio_q[n] <= '0;
          fsel_q[n] <= 1'b0;
        end else if (line_we[n]) begin
          prio_q[n] <= bus_wdata[2 +: PRIO_W];
          fsel_q[n] <= bus_wdata[0];
        end
      end
    end
  end

  always_comb begin
    thr_d     = clr ? '1 : (thr_wr ? bus_wdata[THR_W-1:0] : thr_q);
    sr_pend_d = cfg_wr && !clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q     <= '1;
      sr_pend_q <= 1'b0;
    end else begin
      thr_q     <= thr_d;
      sr_pend_q <= sr_pend_d;
    end
  end

  for (genvar n = 0; n < N_SRC; n++) begin : g_line
    assign prio_flat[n*PRIO_W +: PRIO_W] = prio_q[n];
    assign thr_ok[n] = (thr_q == '1) || (THR_W'(prio_q[n]) < thr_q);
  end

  assign irq_cand = pirq_all & thr_ok;
  assign fiq_cand = pfiq_all & thr_ok;

  // ---------------- arbitration ----------------
  intc_arb #(.N(N_SRC), .PW(PRIO_W), .SW(SW)) u_arb_irq (
    .cand(irq_cand), .prio_flat(prio_flat),
    .found(irq_found), .win(irq_win), .win_prio(irq_wpri));
  intc_arb #(.N(N_SRC), .PW(PRIO_W), .SW(SW)) u_arb_fiq (
    .cand(fiq_cand), .prio_flat(prio_flat),
    .found(fiq_found), .win(fiq_win), .win_prio(fiq_wpri));

  always_comb begin
    irq_take  = !clr && !ack_irq && !irq_vld_q && irq_found;
    fiq_take  = !clr && !ack_fiq && !fiq_vld_q && fiq_found;
    irq_vld_d = (clr || ack_irq) ? 1'b0 : (irq_vld_q || irq_found);
    fiq_vld_d = (clr || ack_fiq) ? 1'b0 : (fiq_vld_q || fiq_found);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_vld_q <= 1'b0;
      irq_num_q <= '0;
      irq_pri_q <= '0;
      fiq_vld_q <= 1'b0;
      fiq_num_q <= '0;
      fiq_pri_q <= '0;
    end else begin
      irq_vld_q <= irq_vld_d;
      fiq_vld_q <= fiq_vld_d;
      if (irq_take) begin
        irq_num_q <= irq_win;
        irq_pri_q <= irq_wpri;
      end
      if (fiq_take) begin
        fiq_num_q <= fiq_win;
        fiq_pri_q <= fiq_wpri;
      end
    end
  end

  assign irq_o = irq_vld_q;
  assign fiq_o = fiq_vld_q;

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    if (bank_hit) begin
      case (bank_reg_e'(bus_addr[4:2]))
        B_RAW:   bus_rdata = src_in[bank_idx*32 +: 32];
        B_MASK:  bus_rdata = mask_all[bank_idx*32 +: 32];
        B_PIRQ:  bus_rdata = pirq_all[bank_idx*32 +: 32];
        B_PFIQ:  bus_rdata = pfiq_all[bank_idx*32 +: 32];
        default: bus_rdata = '0;
      endcase
    end else if (line_hit) begin
      bus_rdata = (32'(prio_q[line_idx]) << 2) | 32'(fsel_q[line_idx]);
    end else begin
      case (bus_addr)
        A_STAT:  bus_rdata = {31'd0, ~sr_pend_q};
        A_AIRQ:  bus_rdata = 32'(irq_num_q);
        A_AFIQ:  bus_rdata = 32'(fiq_num_q);
        A_PIRQ:  bus_rdata = 32'(irq_pri_q);
        A_PFIQ:  bus_rdata = 32'(fiq_pri_q);
        A_THR:   bus_rdata = 32'(thr_q);
        default: bus_rdata = '0;
      endcase
    end
  end

  // ---------------- assertions ----------------
  AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_found |-> irq_cand[irq_win]); // R7
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_irq && !clr) |=> (irq_o && $stable(irq_num_q))); // R8
  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_irq |=> !irq_o); // R8
  AST_FIQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_o && !ack_fiq && !clr) |=> (fiq_o && $stable(fiq_num_q))); // R9
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    sr_pend_q |=> (!irq_o && !fiq_o && thr_q == '1)); // R11
endmodule

// File: tb/test_prio_intc.sv
module test_prio_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [95:0] src = '0;
  logic        irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  prio_intc i_prio_intc (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src),
    .irq_o(irq_o), .fiq_o(fiq_o));

  always #5 clk = ~clk;

  // ---------------- behavioural reference ----------------
  bit m_mask[96], m_swi[96], m_fiq[96];
  int m_prio[96];
  int m_thr, m_inum, m_fnum, m_ipri, m_fpri;
  bit m_iv, m_fv, m_srp;

  task automatic m_reset();
    for (int n = 0; n < 96; n++) begin
      m_mask[n] = 1; m_swi[n] = 0; m_fiq[n] = 0; m_prio[n] = 0;
    end
    m_thr = 255; m_iv = 0; m_fv = 0; m_srp = 0;
    m_inum = 0; m_fnum = 0; m_ipri = 0; m_fpri = 0;
  endtask

  function automatic bit live(int n);
    return (src[n] || m_swi[n]) && !m_mask[n];
  endfunction

  task automatic pick(input bit want_f, output bit f, output int num, output int p);
    f = 0; num = 0; p = 0;
    for (int n = 0; n < 96; n++)
      if (live(n) && m_fiq[n] == want_f && (m_thr == 255 || m_prio[n] < m_thr))
        if (!f || m_prio[n] < p) begin f = 1; num = n; p = m_prio[n]; end
  endtask

  function automatic int exp_read(int a);
    int v;
    v = 0;
    if (a >= 'h80 && a < 'hE0) begin
      for (int j = 0; j < 32; j++) begin
        int n;
        bit b;
        n = ((a - 'h80) / 32) * 32 + j;
        case ((a % 32) / 4)
          0: b = src[n];
          1: b = m_mask[n];
          6: b = live(n) && !m_fiq[n];
          7: b = live(n) && m_fiq[n];
          default: b = 0;
        endcase
        if (b) v = v | (1 << j);
      end
    end else if (a >= 'h100 && a < 'h280) begin
      v = (m_prio[(a - 'h100) / 4] << 2) | int'(m_fiq[(a - 'h100) / 4]);
    end else begin
      case (a)
        'h14: v = m_srp ? 0 : 1;
        'h40: v = m_inum;
        'h44: v = m_fnum;
        'h60: v = m_ipri;
        'h64: v = m_fpri;
        'h68: v = m_thr;
        default: v = 0;
      endcase
    end
    return v;
  endfunction

  always @(posedge clk) begin
    bit fi, ff;
    int ni, nf, pi, pf, a, w;
    if (!rst_n) m_reset();
    else if (m_srp) begin
      m_reset();
      m_srp = 0;
    end else begin
      pick(0, fi, ni, pi);
      pick(1, ff, nf, pf);
      a = int'(bus_addr);
      w = int'(bus_wdata);
      if (bus_wr && a == 'h48 && w[0]) m_iv = 0;
      else if (!m_iv && fi) begin m_iv = 1; m_inum = ni; m_ipri = pi; end
      if (bus_wr && a == 'h48 && w[1]) m_fv = 0;
      else if (!m_fv && ff) begin m_fv = 1; m_fnum = nf; m_fpri = pf; end
      if (bus_wr) begin
        if (a == 'h10 && w[1]) m_srp = 1;
        if (a == 'h68) m_thr = w & 'hFF;
        if (a >= 'h100 && a < 'h280) begin
          m_prio[(a - 'h100) / 4] = (w >> 2) & 'h3F;
          m_fiq[(a - 'h100) / 4]  = w[0];
        end
        if (a >= 'h80 && a < 'hE0)
          for (int j = 0; j < 32; j++) begin
            int n;
            n = ((a - 'h80) / 32) * 32 + j;
            if (w[j])
              case ((a % 32) / 4)
                2: m_mask[n] = 0;
                3: m_mask[n] = 1;
                4: m_swi[n]  = 1;
                5: m_swi[n]  = 0;
                default: ;
              endcase
          end
      end
    end
    #2;
    if (rst_n && !done) begin
      checks++;
      if (irq_o !== m_iv || fiq_o !== m_fv) begin
        errors++;
        $display("FAIL R8/R9 per-clock: irq_o=%0b fiq_o=%0b expected %0b %0b",
                 irq_o, fiq_o, m_iv, m_fv);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = 12'(a); bus_wdata = 32'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    bus_addr = 12'(a);
    #1;
    chk(int'(bus_rdata), exp_read(a), {tag, " model"});
    chk(int'(bus_rdata), exp, tag);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    rd('h14, 1, "R1 status");
    rd('h68, 'hFF, "R1 threshold");
    rd('h84, 32'hFFFF_FFFF, "R1 mask bank0");
    rd('hC4, 32'hFFFF_FFFF, "R1 mask bank2");
    chk(int'(irq_o), 0, "R1 irq_o");

    src[33] = 1; src[64] = 1;
    tick(1);
    rd('hA0, 32'h2, "R3 raw bank1");
    rd('hC0, 32'h1, "R3 raw bank2");
    rd('hB8, 0, "R5 masked not pending");
    src = '0;

    wr('h88, 'hA0);
    rd('h84, 32'hFFFF_FF5F, "R2 mask clear");
    wr('h8C, 'h0);
    wr('h88, 'h0);
    rd('h84, 32'hFFFF_FF5F, "R2 zero bits");
    wr('h8C, 'h20);
    rd('h84, 32'hFFFF_FF7F, "R2 mask set");
    rd('h8C, 0, "R2 alias reads zero");
    wr('h88, 'h20);

    wr('h100 + 4*5, 'h0E);
    wr('h100 + 4*7, 'h0C);
    rd('h100 + 4*5, 'h0C, "R6 line readback");
    src[5] = 1; src[7] = 1;
    tick(2);
    rd('h98, 'hA0, "R5 pending irq");
    rd('h40, 5, "R7 tie to lower number");
    rd('h60, 3, "R7 winner priority");
    chk(int'(irq_o), 1, "R8 irq_o high");

    wr('h100 + 4*7, 'h04);
    tick(1);
    rd('h40, 5, "R8 held until ack");
    wr('h48, 1);
    chk(int'(irq_o), 0, "R8 drop after ack");
    tick(1);
    rd('h40, 7, "R7 lowest value wins");
    rd('h60, 1, "R7 new priority");

    src = '0;
    wr('h48, 1);
    wr('hA8, 'h100);
    wr('hB0, 'h100);
    tick(1);
    rd('hB8, 'h100, "R4 swi pending");
    rd('h40, 40, "R4 swi latched");
    wr('hB4, 'h100);
    wr('h48, 1);
    tick(1);
    rd('hB8, 0, "R4 swi cleared");
    chk(int'(irq_o), 0, "R4 no request");

    wr('h100 + 4*70, 'h09);
    wr('hC8, 'h40);
    src[70] = 1;
    tick(1);
    rd('h44, 70, "R9 fiq winner");
    rd('h64, 2, "R9 fiq priority");
    rd('hDC, 'h40, "R5 pending fiq");
    rd('hD8, 0, "R5 not in irq view");
    chk(int'(fiq_o), 1, "R9 fiq_o");
    chk(int'(irq_o), 0, "R9 irq_o quiet");
    src[70] = 0;
    wr('h48, 2);
    tick(1);
    chk(int'(fiq_o), 0, "R9 fiq released");

    wr('h68, 2);
    src[5] = 1;
    tick(2);
    chk(int'(irq_o), 0, "R10 above threshold blocked");
    rd('h98, 'h20, "R10 pending view unfiltered");
    src[7] = 1;
    tick(1);
    rd('h40, 7, "R10 below threshold passes");
    src[7] = 0;
    wr('h68, 'hFF);
    wr('h48, 1);
    tick(1);
    rd('h40, 5, "R10 disabled by 0xFF");

    wr('h10, 2);
    rd('h14, 0, "R11 busy");
    tick(1);
    rd('h14, 1, "R11 done");
    rd('h84, 32'hFFFF_FFFF, "R11 masks restored");
    rd('h100 + 4*7, 0, "R11 lines restored");
    rd('h68, 'hFF, "R11 threshold restored");
    chk(int'(irq_o), 0, "R11 irq_o low");
    tick(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule